// File: doc/BRIEF.md
# Circular Sample Buffer Controller

This block sequences a multi-channel ring of sample storage with two phases. In the write phase, one word holding a sample for every channel is stored per clock into a ring of cells. The cell pointer moves forward one step per cycle and returns to cell 0 after the last cell. When a stop request arrives, writing halts and the pointer keeps its position. The next write phase continues from that position.

The read phase follows on its own. It starts at the oldest stored cell, which is the one the pointer now addresses (just after the last cell written), and walks forward with wraparound. Before each cell it waits a fixed settling interval. It then places every channel of that cell on one shared sample output, one channel per cycle. This includes the dummy channels kept for common-mode correction.

The number of cells read is programmable. After the last cell, the address of that cell is sent on the same output as a short serial trailer. A one-cycle done pulse then returns the block to idle, where a start input arms the next write phase. Both phases run on one clock. Any difference between write rate and read rate is set by the clock supplied during each phase.

Top module: `ring_sample_ctrl`

## Requirements
- R1: In the write phase the stored cell address advances by one per clock, and after cell 510 the next cell written is cell 0.
- R2: A stop request in the write phase ends writing at that edge; the write pointer keeps its value, and the next write phase continues from it.
- R3: Readout begins at the cell the write pointer holds after the stop (the oldest sample) and moves to ascending cells, wrapping from 510 to 0.
- R4: Before each cell's data, `smp_valid` stays low for exactly 3 clock cycles.
- R5: Each cell is then presented as 76 consecutive valid samples, with `smp_chan` counting 0 to 75, and `smp_data` equal to bits [12*c+11:12*c] of the word written into that cell.
- R6: The number of cells read equals `cell_count`, latched when start is accepted; a value of 0 or above 511 is treated as 511.
- R7: After the last channel of the last cell, 9 trailer cycles follow with `smp_valid` and `smp_trailer` high, carrying the last cell address MSB first; a 1 bit appears as 12'hFFF and a 0 bit as 12'h000.
- R8: `done` is high for exactly the one cycle after the last trailer bit, and then `busy` falls. `busy` is high from the first write cycle through the done cycle.
- R9: A stop request held during the read phase has no effect on the read sequence or on the retained write pointer.
- R10: While `rst_n` is low, `busy`, `smp_valid` and `done` are low. After reset the write pointer is at cell 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both phases |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms a write phase when idle |
| stop | input | 1 | Ends the write phase (trigger) |
| cell_count | input | 10 | Number of cells to read (0 or >511 means 511) |
| wr_samples | input | 912 | One 12-bit sample per channel, channel c at bits [12c+11:12c] |
| busy | output | 1 | High outside the idle state |
| smp_valid | output | 1 | Output sample valid |
| smp_trailer | output | 1 | Current sample is a trailer bit |
| smp_chan | output | 7 | Channel index of the current sample |
| smp_data | output | 12 | Shared sample output |
| done | output | 1 | One-cycle end-of-readout pulse |

## Verification
The stop is sampled at one rising edge. The three following cycles carry no valid sample, channel 0 of the oldest cell appears in the fourth cycle, and each further cell occupies 79 cycles: 3 settle and 76 channels. The trailer fills the 9 cycles right after channel 75 of the last cell, and done comes in the single cycle after that, with busy low one cycle later. The bench follows this schedule one falling edge at a time, checking every cycle of the read phase against a cell model it keeps from its own writes. Several runs in a row check that the pointer is kept from one write phase to the next.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WRITE,
    PH_SETTLE,
    PH_CHAN,
    PH_TRAIL,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/rsc_ring_ptr.sv
module rsc_ring_ptr #(
  parameter int CELLS = 511,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(CELLS - 1);

  logic [AW-1:0] ptr_n;

  always_comb begin
    ptr_n = ptr;
    if (ld)      ptr_n = ld_val;
    else if (en) ptr_n = (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr <= '0;
    else if (ld || en)  ptr <= ptr_n;
  end

  // R1
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld && ptr == LAST) |=> (ptr == '0));

  // R1
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/rsc_ring_mem.sv
module rsc_ring_mem #(
  parameter int CELLS = 511,
  parameter int AW    = 9,
  parameter int W     = 912
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [CELLS];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/rsc_seq.sv
module rsc_seq
  import rsc_pkg::*;
#(
  parameter int CELLS  = 511,
  parameter int AW     = 9,
  parameter int CHANS  = 76,
  parameter int SETTLE = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         stop,
  input  logic [AW:0]                  cell_count,
  output phase_t                       phase,
  output logic                         wr_en,
  output logic                         rd_ld,
  output logic                         rd_step,
  output logic [$clog2(CHANS)-1:0]     chan,
  output logic [$clog2(AW)-1:0]        tbit
);
  localparam int CW = $clog2(CHANS);
  localparam int SW = $clog2(SETTLE + 1);
  localparam int TW = $clog2(AW);

  phase_t         phase_n;
  logic [SW-1:0]  set_cnt, set_cnt_n;
  logic [CW-1:0]  chan_n;
  logic [AW-1:0]  cell_num, cell_num_n;
  logic [AW-1:0]  lim, lim_n;
  logic [TW-1:0]  tbit_n;
  logic [AW-1:0]  clamped;

  assign clamped = (cell_count == '0 || cell_count > (AW+1)'(CELLS))
                   ? AW'(CELLS) : cell_count[AW-1:0];

  always_comb begin
    phase_n    = phase;
    set_cnt_n  = set_cnt;
    chan_n     = chan;
    cell_num_n = cell_num;
    lim_n      = lim;
    tbit_n     = tbit;
    wr_en      = 1'b0;
    rd_ld      = 1'b0;
    rd_step    = 1'b0;
    unique case (phase)
      PH_IDLE: if (start) begin
        phase_n = PH_WRITE;
        lim_n   = clamped;
      end
      PH_WRITE: if (stop) begin
        phase_n    = PH_SETTLE;
        set_cnt_n  = '0;
        cell_num_n = '0;
        rd_ld      = 1'b1;
      end else begin
        wr_en = 1'b1;
      end
      PH_SETTLE: if (set_cnt == SW'(SETTLE - 1)) begin
        phase_n = PH_CHAN;
        chan_n  = '0;
      end else begin
        set_cnt_n = set_cnt + 1'b1;
      end
      PH_CHAN: if (chan == CW'(CHANS - 1)) begin
        if (cell_num == lim - 1'b1) begin
          phase_n = PH_TRAIL;
          tbit_n  = TW'(AW - 1);
        end else begin
          phase_n    = PH_SETTLE;
          set_cnt_n  = '0;
          cell_num_n = cell_num + 1'b1;
          rd_step    = 1'b1;
        end
      end else begin
        chan_n = chan + 1'b1;
      end
      PH_TRAIL: if (tbit == '0) phase_n = PH_DONE;
                else tbit_n = tbit - 1'b1;
      PH_DONE:  phase_n = PH_IDLE;
      default:  phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      set_cnt  <= '0;
      chan     <= '0;
      cell_num <= '0;
      lim      <= AW'(CELLS);
      tbit     <= '0;
    end else begin
      phase    <= phase_n;
      set_cnt  <= set_cnt_n;
      chan     <= chan_n;
      cell_num <= cell_num_n;
      lim      <= lim_n;
      tbit     <= tbit_n;
    end
  end

  // R4
  settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CHAN && $past(phase) != PH_CHAN) |-> ($past(set_cnt) == SW'(SETTLE - 1)));

  // R5
  chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CHAN && chan != CW'(CHANS - 1)) |=> (phase == PH_CHAN && chan == $past(chan) + 1'b1));

  // R6
  cell_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CHAN) |-> (cell_num < lim));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |=> (phase == PH_IDLE));
endmodule

// File: rtl/ring_sample_ctrl.sv
module ring_sample_ctrl
  import rsc_pkg::*;
#(
  parameter int CELLS  = 511,
  parameter int CHANS  = 76,
  parameter int DW     = 12,
  parameter int SETTLE = 3,
  localparam int AW    = $clog2(CELLS + 1),
  localparam int CW    = $clog2(CHANS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                stop,
  input  logic [AW:0]         cell_count,
  input  logic [CHANS*DW-1:0] wr_samples,
  output logic                busy,
  output logic                smp_valid,
  output logic                smp_trailer,
  output logic [CW-1:0]       smp_chan,
  output logic [DW-1:0]       smp_data,
  output logic                done
);
  localparam int TW = $clog2(AW);

  phase_t              phase;
  logic                wr_en, rd_ld, rd_step;
  logic [CW-1:0]       chan;
  logic [TW-1:0]       tbit;
  logic [AW-1:0]       wptr, rcell;
  logic [CHANS*DW-1:0] rword;

  rsc_seq #(.CELLS(CELLS), .AW(AW), .CHANS(CHANS), .SETTLE(SETTLE)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .cell_count(cell_count), .phase(phase), .wr_en(wr_en),
    .rd_ld(rd_ld), .rd_step(rd_step), .chan(chan), .tbit(tbit)
  );

  rsc_ring_ptr #(.CELLS(CELLS), .AW(AW)) u_wptr (
    .clk(clk), .rst_n(rst_n), .en(wr_en), .ld(1'b0), .ld_val('0), .ptr(wptr)
  );

  rsc_ring_ptr #(.CELLS(CELLS), .AW(AW)) u_rptr (
    .clk(clk), .rst_n(rst_n), .en(rd_step), .ld(rd_ld), .ld_val(wptr), .ptr(rcell)
  );

  rsc_ring_mem #(.CELLS(CELLS), .AW(AW), .W(CHANS*DW)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wptr), .wdata(wr_samples),
    .raddr(rcell), .rdata(rword)
  );

  always_comb begin
    busy        = (phase != PH_IDLE);
    smp_valid   = (phase == PH_CHAN) || (phase == PH_TRAIL);
    smp_trailer = (phase == PH_TRAIL);
    done        = (phase == PH_DONE);
    smp_chan    = chan;
    smp_data    = '0;
    if (phase == PH_CHAN)       smp_data = rword[int'(chan)*DW +: DW];
    else if (phase == PH_TRAIL) smp_data = rcell[tbit] ? '1 : '0;
  end

  // R9
  wptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && phase != PH_WRITE) |=> $stable(wptr));

  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: tb/ring_sample_ctrl_tb.sv
module ring_sample_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCELL = 511;
  localparam int NCH   = 76;
  // fields: write cycles, cell_count, hold stop in read, expected cells
  localparam int VEC [6][4] = '{
    '{600, 3,   0, 3},
    '{20,  5,   0, 5},
    '{450, 2,   1, 2},
    '{40,  0,   0, 511},
    '{7,   700, 1, 511},
    '{9,   1,   0, 1}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start, stop;
  logic [9:0]      cell_count;
  logic [NCH*12-1:0] wr_samples;
  logic            busy, smp_valid, smp_trailer, done;
  logic [6:0]      smp_chan;
  logic [11:0]     smp_data;

  int checks = 0;
  int fails  = 0;
  int bmem [NCELL];
  int bptr  = 0;
  int tglob = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_sample_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .cell_count(cell_count), .wr_samples(wr_samples), .busy(busy),
    .smp_valid(smp_valid), .smp_trailer(smp_trailer), .smp_chan(smp_chan),
    .smp_data(smp_data), .done(done)
  );

  function automatic logic [11:0] pat(int t, int ch);
    return 12'((t * 37 + ch * 101 + 5) & 32'hFFF);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_write();
    for (int ch = 0; ch < NCH; ch++) wr_samples[ch*12 +: 12] = pat(tglob, ch);
    bmem[bptr] = tglob;
    tglob++;
    bptr = (bptr + 1) % NCELL;
  endtask

  task automatic run_vec(int wc, int cnt, bit hold, int expc);
    int rc, last;
    @(negedge clk); start = 1'b1; cell_count = cnt[9:0];
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R8 busy in write", int'(busy), 1);
    for (int w = 0; w < wc; w++) begin
      drive_write();              // R1 one cell per clock
      @(negedge clk);
    end
    stop = 1'b1;                  // R2 stop ends writing
    @(negedge clk);
    stop = hold;                  // R9 stop held in read phase
    rc = bptr;                    // R3 oldest cell
    last = rc;
    for (int c = 0; c < expc; c++) begin
      for (int s = 0; s < 3; s++) begin
        chk(smp_valid == 1'b0, "R4 settle gap", int'(smp_valid), 0);
        @(negedge clk);
      end
      for (int ch = 0; ch < NCH; ch++) begin
        chk(smp_valid && !smp_trailer, "R5 valid", int'(smp_valid), 1);
        chk(int'(smp_chan) == ch, "R5 channel index", int'(smp_chan), ch);
        if (bmem[rc] >= 0)
          chk(smp_data == pat(bmem[rc], ch), "R3 R5 R6 cell data",
              int'(smp_data), int'(pat(bmem[rc], ch)));
        @(negedge clk);
      end
      last = rc;
      rc = (rc + 1) % NCELL;
    end
    for (int b = 8; b >= 0; b--) begin
      chk(smp_valid && smp_trailer, "R7 trailer flags", int'(smp_trailer), 1);
      chk(smp_data == (last[b] ? 12'hFFF : 12'h000), "R7 trailer bit",
          int'(smp_data), last[b] ? 4095 : 0);
      @(negedge clk);
    end
    chk(done == 1'b1 && busy == 1'b1, "R8 done pulse", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8 back to idle", int'(busy), 0);
    stop = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCELL; i++) bmem[i] = -1;
    rst_n = 1'b0; start = 1'b0; stop = 1'b0; cell_count = '0; wr_samples = '0;
    repeat (2) @(negedge clk);
    // R10 reset state
    chk(!busy && !smp_valid && !done, "R10 reset outputs", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R10 idle after reset", int'(busy), 0);

    for (int v = 0; v < 6; v++)
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2] != 0, VEC[v][3]);

    // R10 reset during write clears pointer and returns to idle
    @(negedge clk); start = 1'b1; cell_count = 10'd4;
    @(negedge clk); start = 1'b0;
    for (int w = 0; w < 50; w++) begin
      drive_write();
      @(negedge clk);
    end
    rst_n = 1'b0;
    #1;
    chk(!busy && !smp_valid && !done, "R10 async reset in write", int'(busy), 0);
    bptr = 0;
    @(negedge clk); rst_n = 1'b1;
    // pointer back at 0: three writes, readout from cell 3, trailer reports cell 4
    run_vec(3, 2, 1'b0, 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule